// File: doc/BRIEF.md
# UV-Erasable Byte Memory Emulator

This block is a clocked, synthesizable stand-in for a 2048 x 8 memory that can only be written by clearing bits and can only be returned to all ones by a full erase. It sits behind a device-style pin interface. That interface has an 11-bit address, an 8-bit data path split into an input, an output and an output-drive flag, an active-low output enable, a combined chip-enable and program-pulse pin, and a flag that says the programming supply is raised. Every cycle the block decodes the pin levels into one of six operating modes and drives the data bus only in the two modes that return stored data.

A write happens at the falling edge of a high pulse on the chip-enable pin. The pulse only counts while the programming supply is raised and the output enable is held high. The block measures the pulse width in clock cycles against a parameterized window. A pulse inside the window ANDs the data pins into the addressed byte. A pulse outside the window writes nothing and sets a sticky error flag.

An erase request sweeps the array to all ones at one address per clock while a busy flag is high. Reset starts the same sweep, so the array starts out blank. Read data and the drive flag pass through a pipeline whose depth is a parameter.

Top module: `uv_prom_emu`

## Requirements
- R1: After reset, and after any erase sweep, every address reads 0xFF.
- R2: A valid program pulse sets the addressed byte to (old AND data_i), so 1 bits on data_i never set a stored 0.
- R3: With vpp_hi_i=0, cep_i=0 and oe_ni=0 (read), the block drives data_oe_o=1 and data_o equal to the byte at addr_i.
- R4: With vpp_hi_i=0 and oe_ni=1, the bus is released for either level of cep_i. Released means data_oe_o=0 and data_o=0.
- R5: With vpp_hi_i=0 and cep_i=1, the bus is released for either level of oe_ni.
- R6: With vpp_hi_i=1, cep_i=0 and oe_ni=0 (verify), the block drives the stored byte exactly as in read mode.
- R7: With vpp_hi_i=1, oe_ni=1 and cep_i held low (inhibit), the bus is released and no byte changes, whatever data_i is.
- R8: A pulse counts only while vpp_hi_i=1 and oe_ni=1. Its width is the number of clock edges at which cep_i is sampled high. A width from PW_MIN to PW_MAX inclusive writes at the edge where cep_i is first sampled low again.
- R9: A pulse width below PW_MIN or above PW_MAX writes nothing and sets err_o. err_o stays set until reset.
- R10: When erase_i is sampled high while busy_o=0, busy_o is high from the next cycle for exactly 2^ADDR_W cycles. Erase requests and program pulses are ignored while busy_o=1, and busy_o is also high for 2^ADDR_W cycles after reset is released.
- R11: The drive flag and the data reflect the mode and address sampled RD_LAT clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Data pins as seen when programming |
| data_o | output | DATA_W | Data pins as driven; 0 when not driving |
| data_oe_o | output | 1 | High when the block drives the data pins |
| oe_ni | input | 1 | Output enable, active low |
| cep_i | input | 1 | Chip enable (active low) and program pulse (active high) |
| vpp_hi_i | input | 1 | Programming supply raised |
| erase_i | input | 1 | Start an erase sweep |
| busy_o | output | 1 | Erase sweep in progress |
| err_o | output | 1 | Sticky flag for a pulse outside the width window |

## Verification
A wrong stored byte stays hidden until that address is read or verified, so the bench reads back every address after each erase and each programming pass. The bad byte then shows on data_o RD_LAT cycles after the read is set up. A pulse counter that is off by one shows as a missing write or a false error only at the boundary widths PW_MIN-1, PW_MIN, PW_MAX and PW_MAX+1, so each of these widths is applied. A sweep counter fault shows in the length of busy_o, which the bench counts in cycles, or as a non-blank byte in the full read after the sweep.

// File: rtl/uvp_pkg.sv
package uvp_pkg;
  typedef enum logic [2:0] {
    MD_READ,
    MD_DESEL,
    MD_STBY,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_CLASH
  } mode_e;

  function automatic mode_e decode_mode(input logic vpp_hi, input logic cep, input logic oe_n);
    if (!vpp_hi) begin
      if (cep) return MD_STBY;
      if (oe_n) return MD_DESEL;
      return MD_READ;
    end
    if (oe_n) return cep ? MD_PROG : MD_INHIBIT;
    // raised supply, chip high, outputs enabled: no defined mode, stay quiet
    return cep ? MD_CLASH : MD_VERIFY;
  endfunction
endpackage

// File: rtl/uvp_mode_dec.sv
module uvp_mode_dec
  import uvp_pkg::*;
(
  input  logic  vpp_hi_i,
  input  logic  cep_i,
  input  logic  oe_ni,
  output mode_e mode_o,
  output logic  drive_o,
  output logic  prog_en_o
);
  always_comb begin
    mode_o    = decode_mode(vpp_hi_i, cep_i, oe_ni);
    drive_o   = (mode_o == MD_READ) || (mode_o == MD_VERIFY);
    // pulse tracking window: program or inhibit, cep level picks which
    prog_en_o = (mode_o == MD_PROG) || (mode_o == MD_INHIBIT);
  end
endmodule

// File: rtl/uvp_pulse_timer.sv
module uvp_pulse_timer #(
  parameter int unsigned PW_MIN = 11250000,
  parameter int unsigned PW_MAX = 13750000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic pulse_i,
  output logic wr_go_o,
  output logic bad_o
);
  localparam int unsigned CW = $clog2(PW_MAX + 2);
  localparam logic [CW-1:0] CMIN = CW'(PW_MIN);
  localparam logic [CW-1:0] CMAX = CW'(PW_MAX);
  localparam logic [CW-1:0] CSAT = CW'(PW_MAX + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          end_w;
  logic          in_win;

  assign end_w   = arm_i && active_q && !pulse_i;
  assign in_win  = (cnt_q >= CMIN) && (cnt_q <= CMAX);
  assign wr_go_o = end_w && in_win;
  assign bad_o   = end_w && !in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!arm_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (pulse_i) begin
      active_q <= 1'b1;
      if (cnt_q != CSAT) cnt_q <= cnt_q + 1'b1;
    end else begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end
  end
endmodule

// File: rtl/uvp_array.sv
module uvp_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] sweep_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end else if (busy_q) begin
      if (sweep_q == LAST) busy_q <= 1'b0;
      sweep_q <= sweep_q + 1'b1;
    end else if (erase_i) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (busy_q) mem[sweep_q] <= '1;
    else if (wr_i) mem[addr_i] <= mem[addr_i] & wdata_i;
  end

  assign rdata_o = mem[addr_i];
  assign busy_o  = busy_q;
endmodule

// File: rtl/uvp_out_pipe.sv
module uvp_out_pipe #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o
);
  logic [LAT-1:0]    drv_q;
  logic [DATA_W-1:0] dat_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          drv_q[0] <= 1'b0;
          dat_q[0] <= '0;
        end else begin
          drv_q[0] <= drive_i;
          dat_q[0] <= drive_i ? data_i : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          drv_q[g] <= 1'b0;
          dat_q[g] <= '0;
        end else begin
          drv_q[g] <= drv_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  end

  assign oe_o   = drv_q[LAT-1];
  assign data_o = dat_q[LAT-1];
endmodule

// File: rtl/uv_prom_emu.sv
module uv_prom_emu
  import uvp_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PW_MIN = 11250000,
  parameter int unsigned PW_MAX = 13750000,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              oe_ni,
  input  logic              cep_i,
  input  logic              vpp_hi_i,
  input  logic              erase_i,
  output logic              busy_o,
  output logic              err_o
);
  mode_e             mode;
  logic              drive;
  logic              prog_en;
  logic              wr_go;
  logic              bad;
  logic              err_q;
  logic [DATA_W-1:0] rdata;

  uvp_mode_dec u_dec (
    .vpp_hi_i (vpp_hi_i),
    .cep_i    (cep_i),
    .oe_ni    (oe_ni),
    .mode_o   (mode),
    .drive_o  (drive),
    .prog_en_o(prog_en)
  );

  uvp_pulse_timer #(.PW_MIN(PW_MIN), .PW_MAX(PW_MAX)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (prog_en && !busy_o),
    .pulse_i(cep_i),
    .wr_go_o(wr_go),
    .bad_o  (bad)
  );

  uvp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .erase_i(erase_i),
    .wr_i   (wr_go),
    .addr_i (addr_i),
    .wdata_i(data_i),
    .rdata_o(rdata),
    .busy_o (busy_o)
  );

  uvp_out_pipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drive_i(drive && !busy_o),
    .data_i (rdata),
    .oe_o   (data_oe_o),
    .data_o (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/uv_prom_emu_chk.sv
module uv_prom_emu_chk #(
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              erase_i,
  input logic              busy_o,
  input logic              err_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              wr_go_i,
  input logic              bad_i
);
  localparam int unsigned BW = $clog2(DEPTH + 1) + 1;
  logic [BW-1:0] bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt_q <= '0;
    else if (busy_o) bcnt_q <= bcnt_q + 1'b1;
    else bcnt_q <= '0;
  end

  p_release_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_bad_sets_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> err_o);
  p_erase_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i && !busy_o) |=> busy_o);
  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt_q == BW'(DEPTH));
  p_busy_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt_q < BW'(DEPTH));
  p_no_write_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_go_i);
endmodule

bind uv_prom_emu uv_prom_emu_chk #(.DEPTH(1 << ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .erase_i  (erase_i),
  .busy_o   (busy_o),
  .err_o    (err_o),
  .data_oe_o(data_oe_o),
  .data_o   (data_o),
  .wr_go_i  (wr_go),
  .bad_i    (bad)
);

// File: tb/tb_uv_prom_emu.sv
module tb_uv_prom_emu;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PMIN = 5;
  localparam int PMAX = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doe;
  logic          oe_n = 1'b1;
  logic          cep = 1'b1;
  logic          vpp = 1'b0;
  logic          erase = 1'b0;
  logic          busy;
  logic          err;

  int total = 0;
  int bad = 0;
  int exp_mem [DEPTH];
  bit exp_err = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uv_prom_emu #(.ADDR_W(AW), .DATA_W(DW), .PW_MIN(PMIN), .PW_MAX(PMAX), .RD_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .oe_ni(oe_n), .cep_i(cep), .vpp_hi_i(vpp), .erase_i(erase),
    .busy_o(busy), .err_o(err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    vpp = 1'b0; cep = 1'b1; oe_n = 1'b1;
  endtask

  task automatic read_at(input int a, input bit hv, output int d, output int oe);
    @(negedge clk);
    addr = AW'(a); vpp = hv; cep = 1'b0; oe_n = 1'b0;
    repeat (LAT) @(negedge clk);
    d = int'(dout); oe = int'(doe);
  endtask

  task automatic pulse(input int a, input int d, input int len);
    @(negedge clk);
    vpp = 1'b1; oe_n = 1'b1; cep = 1'b0; addr = AW'(a); din = DW'(d);
    @(negedge clk);
    cep = 1'b1;
    repeat (len) @(negedge clk);
    cep = 1'b0;
    repeat (2) @(negedge clk);
    if (!busy) begin
      if (len >= PMIN && len <= PMAX) exp_mem[a] = exp_mem[a] & d;
      else exp_err = 1'b1;
    end
    idle();
  endtask

  task automatic read_all(input string req, input bit hv);
    int d, oe;
    for (int a = 0; a < DEPTH; a++) begin
      read_at(a, hv, d, oe);
      check(req, d, exp_mem[a]);
      check(req, oe, 1);
    end
    idle();
  endtask

  function automatic int pat(input int a, input int k);
    return ((a * 37 + k * 11 + 5) ^ (a << 3)) & 8'hFF;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int d, oe, n;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    check("R10 reset busy", int'(busy), 1);
    check("R4 reset released", int'(doe), 0);
    check("R9 reset err", int'(err), 0);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 4 * DEPTH) begin n++; @(negedge clk); end
    check("R10 reset sweep length", n, DEPTH);

    read_all("R1 R3 blank after reset", 1'b0);

    // deselect and standby, several addresses, both levels of the free pin
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      addr = AW'(k * 7); vpp = 1'b0; oe_n = 1'b1; cep = k[0];
      repeat (LAT) @(negedge clk);
      check("R4 deselect oe", int'(doe), 0);
      check("R4 deselect data", int'(dout), 0);
      @(negedge clk);
      cep = 1'b1; oe_n = k[1];
      repeat (LAT) @(negedge clk);
      check("R5 standby oe", int'(doe), 0);
      check("R5 standby data", int'(dout), 0);
    end

    // latency from deselect to read
    @(negedge clk);
    vpp = 1'b0; cep = 1'b0; oe_n = 1'b1; addr = 3;
    repeat (LAT + 1) @(negedge clk);
    oe_n = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check("R11 not yet driving", int'(doe), 0);
    @(negedge clk);
    check("R11 driving after RD_LAT", int'(doe), 1);
    idle();

    // first pass: every address, widths cycling through the whole window
    for (int a = 0; a < DEPTH; a++) pulse(a, pat(a, 0), PMIN + (a % (PMAX - PMIN + 1)));
    check("R9 no error on valid widths", int'(err), 0);
    read_all("R6 R8 verify first pass", 1'b1);
    read_all("R3 read first pass", 1'b0);

    // second pass on even addresses: AND accumulates, ones do not restore
    for (int a = 0; a < DEPTH; a += 2) pulse(a, pat(a, 1) | 8'h81, PMAX);
    read_all("R2 and-accumulate", 1'b1);

    // inhibit: raised supply, chip low, enable high, data zero
    @(negedge clk);
    vpp = 1'b1; oe_n = 1'b1; cep = 1'b0; addr = 3; din = 8'h00;
    repeat (20) @(negedge clk);
    check("R7 inhibit released", int'(doe), 0);
    idle();
    read_at(3, 1'b1, d, oe);
    check("R7 inhibit no write", d, exp_mem[3]);
    idle();

    // out-of-window pulses
    pulse(7, 8'h00, PMIN - 1);
    check("R9 short pulse err", int'(err), 1);
    read_at(7, 1'b1, d, oe);
    check("R9 short pulse no write", d, exp_mem[7]);
    idle();
    pulse(9, 8'h00, PMAX + 1);
    read_at(9, 1'b1, d, oe);
    check("R9 long pulse no write", d, exp_mem[9]);
    idle();
    check("R9 err sticky", int'(err), 1);
    pulse(11, 8'h0F, PMIN);
    read_at(11, 1'b1, d, oe);
    check("R8 minimum width writes", d, exp_mem[11]);
    idle();

    // erase command: counted sweep
    @(negedge clk);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    n = 0;
    while (busy && n < 4 * DEPTH) begin n++; @(negedge clk); end
    check("R10 erase sweep length", n, DEPTH);
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    read_all("R1 blank after erase", 1'b0);

    // program first, then erase with a pulse landing inside the sweep
    pulse(5, 8'h00, PMIN);
    exp_mem[5] = 8'hFF;
    @(negedge clk);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    check("R10 busy after erase", int'(busy), 1);
    pulse(0, 8'h00, PMIN);
    n = 0;
    while (busy && n < 4 * DEPTH) begin n++; @(negedge clk); end
    read_all("R10 pulse ignored while busy", 1'b1);
    check("R9 err kept across erase", int'(err), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule